// File: doc/BRIEF.md
# Thiran Allpass Fractional Delay

This block delays a stream of signed samples by a fractional number of samples. It uses an allpass IIR filter of order 1 to 3, set at build time, whose group delay is maximally flat around DC. The denominator coefficients are derived from the requested delay D in closed form. The numerator is the same coefficient list in reverse order, so the magnitude response stays at unity and only the phase, close to -D times the frequency, is shaped.

The delay is given as an unsigned fixed-point code with 12 fraction bits, so the code d means D = d/4096. A load strobe starts a sequential computation of the coefficients. The `busy` flag is high while that computation runs, and the new set replaces the active one at the next sample. Samples arrive with a valid strobe. Each one produces a rounded, saturated output one cycle later.

Top module: `thiran_allpass_delay`

## Requirements
- R1: A synchronous reset clears `out_valid`, `out_data`, `busy`, `delay_err`, all input and output history, and every coefficient a1..aN, leaving a0 = 1. After reset, the output for sample n is therefore the input of sample n-ORDER, with zeros for the first ORDER samples.
- R2: When `delay_set` is high and `busy` is low, `delay_in` is taken. `busy` is then high from the next cycle for exactly ORDER*(COEF_W+1) cycles, which is 50 with the defaults.
- R3: A `delay_set` that arrives while `busy` is high has no effect. Both the computation length and the coefficients produced follow the delay already taken.
- R4: A delay code of 0 is computed as code 1, and `delay_err` is high from the next cycle. The next accepted non-zero code clears `delay_err` one cycle after it is taken.
- R5: Each coefficient is a signed 24-bit code with 16 fraction bits, and a0 is 65536. Let P = prod over i=1..k of (d + (i-1-N)*4096), and Q = prod over i=1..k of (d + i*4096). Then a_k = s * floor((|P| * C(N,k) * 65536 + floor(Q/2)) / Q), where s is negative exactly when k is odd xor P < 0.
- R6: A freshly computed set is first used by the first sample accepted after `busy` falls. Samples accepted while `busy` is high use the previous set. Sample history is kept across a change of set.
- R7: For a sample x[n], acc = sum over j=0..N of a_(N-j)*x[n-j], minus sum over j=1..N of a_j*y[n-j]. The output is y[n] = floor((acc + 32768) / 65536), saturated. The y history holds the saturated outputs.
- R8: `out_valid` is high exactly one cycle after each cycle with `in_valid` high and low otherwise. `out_data` changes only when `out_valid` rises or stays high.
- R9: Results above 32767 or below -32768 saturate to those limits.
- R10: A delay of exactly ORDER samples (code ORDER*4096) makes every a_k for k>=1 zero, so the output is the input delayed by exactly ORDER samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| delay_set | input | 1 | Load strobe for a new delay |
| delay_in | input | 16 | Delay, unsigned, 12 fraction bits |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | 16 | Input sample, signed |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | 16 | Output sample, signed, saturated |
| busy | output | 1 | Coefficient computation running |
| delay_err | output | 1 | Last accepted delay was zero and was clamped |

## Verification
An output sample is due one cycle after its input strobe. `busy` and `delay_err` are due one cycle after the load strobe, and `busy` falls exactly ORDER*(COEF_W+1) cycles later. The bench drives inputs on the falling edge and reads each result on the falling edge that follows the rising edge that produces it. It counts `busy` cycles on falling edges, and it switches its arithmetic model to the new coefficient set at the first sample after `busy` drops.

// File: rtl/thiran_allpass_delay.sv
module thiran_allpass_delay #(
  parameter int ORDER      = 2,
  parameter int DATA_W     = 16,
  parameter int DELAY_W    = 16,
  parameter int DELAY_FRAC = 12,
  parameter int COEF_W     = 24,
  parameter int COEF_FRAC  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     delay_set,
  input  logic [DELAY_W-1:0]       delay_in,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     busy,
  output logic                     delay_err
);

  localparam int TW    = DELAY_W + 3;
  localparam int PW    = ORDER * TW + 1;
  localparam int QW    = COEF_W - 1;
  localparam int DW    = PW + COEF_FRAC + QW + 2;
  localparam int KW    = $clog2(ORDER + 1);
  localparam int CW    = $clog2(QW);
  localparam int ACC_W = DATA_W + COEF_W + 4;
  localparam int ONE   = 1 << DELAY_FRAC;
  localparam logic signed [COEF_W-1:0] UNIT = COEF_W'(1 << COEF_FRAC);
  localparam logic signed [ACC_W-1:0]  HALF = ACC_W'(1 << (COEF_FRAC - 1));
  localparam logic signed [ACC_W-1:0]  YMAX = ACC_W'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0]  YMIN = -YMAX - ACC_W'(1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_PREP, S_DIV} phase_t;

  function automatic int binom(input int k);
    int c;
    c = 1;
    for (int i = 1; i <= ORDER; i++)
      if (i <= k) c = c * (ORDER - i + 1) / i;
    return c;
  endfunction

  phase_t                    ph;
  logic [DELAY_W-1:0]        dcode;
  logic [KW-1:0]             kidx;
  logic signed [PW-1:0]      num, den, t_num, t_den;
  logic [PW-1:0]             num_mag;
  logic [DW-1:0]             rem, dsh;
  logic [QW-1:0]             quo, qn;
  logic [CW-1:0]             cnt;
  logic                      neg, pend, apply, ge;
  logic signed [COEF_W-1:0]  coef_cur [1:ORDER];
  logic signed [COEF_W-1:0]  coef_new [1:ORDER];
  logic signed [COEF_W-1:0]  ause     [0:ORDER];
  logic signed [DATA_W-1:0]  xh [1:ORDER];
  logic signed [DATA_W-1:0]  yh [1:ORDER];
  logic signed [ACC_W-1:0]   acc, rnd;
  logic signed [DATA_W-1:0]  ysat;

  assign busy    = (ph != S_IDLE);
  assign apply   = pend & in_valid;
  assign num_mag = num[PW-1] ? PW'(-num) : PW'(num);
  assign ge      = (rem >= dsh);
  assign qn      = {quo[QW-2:0], ge};

  always_comb begin
    t_num = PW'(int'(dcode) + (int'(kidx) - 1 - ORDER) * ONE);
    t_den = PW'(int'(dcode) + int'(kidx) * ONE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= S_IDLE;
      dcode     <= DELAY_W'(ONE);
      kidx      <= '0;
      num       <= '0;
      den       <= '0;
      rem       <= '0;
      dsh       <= '0;
      quo       <= '0;
      cnt       <= '0;
      neg       <= 1'b0;
      pend      <= 1'b0;
      delay_err <= 1'b0;
      for (int i = 1; i <= ORDER; i++) begin
        coef_cur[i] <= '0;
        coef_new[i] <= '0;
      end
    end else begin
      if (apply) begin
        for (int i = 1; i <= ORDER; i++) coef_cur[i] <= coef_new[i];
        pend <= 1'b0;
      end
      case (ph)
        S_IDLE: if (delay_set) begin
          dcode     <= (delay_in == '0) ? DELAY_W'(1) : delay_in;
          delay_err <= (delay_in == '0);
          num       <= PW'(1);
          den       <= PW'(1);
          kidx      <= KW'(1);
          pend      <= 1'b0;
          ph        <= S_MUL;
        end
        S_MUL: begin
          num <= num * t_num;
          den <= den * t_den;
          ph  <= S_PREP;
        end
        S_PREP: begin
          rem <= ((DW'(num_mag) * DW'(binom(int'(kidx)))) << COEF_FRAC)
                 + (DW'($unsigned(den)) >> 1);
          dsh <= DW'($unsigned(den)) << (QW - 1);
          neg <= num[PW-1] ^ kidx[0];
          quo <= '0;
          cnt <= CW'(QW - 1);
          ph  <= S_DIV;
        end
        S_DIV: begin
          if (ge) rem <= rem - dsh;
          dsh <= dsh >> 1;
          quo <= qn;
          cnt <= cnt - 1'b1;
          if (cnt == '0) begin
            coef_new[kidx] <= neg ? -$signed({1'b0, qn}) : $signed({1'b0, qn});
            if (kidx == KW'(ORDER)) begin
              pend <= 1'b1;
              ph   <= S_IDLE;
            end else begin
              kidx <= kidx + 1'b1;
              ph   <= S_MUL;
            end
          end
        end
        default: ph <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ause[0] = UNIT;
    for (int i = 1; i <= ORDER; i++) ause[i] = apply ? coef_new[i] : coef_cur[i];
    acc = ACC_W'(ause[ORDER]) * ACC_W'(in_data);
    for (int j = 1; j <= ORDER; j++)
      acc = acc + ACC_W'(ause[ORDER-j]) * ACC_W'(xh[j]) - ACC_W'(ause[j]) * ACC_W'(yh[j]);
    rnd = (acc + HALF) >>> COEF_FRAC;
    if (rnd > YMAX)      ysat = YMAX[DATA_W-1:0];
    else if (rnd < YMIN) ysat = YMIN[DATA_W-1:0];
    else                 ysat = rnd[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      for (int j = 1; j <= ORDER; j++) begin
        xh[j] <= '0;
        yh[j] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= ysat;
        xh[1]    <= in_data;
        yh[1]    <= ysat;
        for (int j = 2; j <= ORDER; j++) begin
          xh[j] <= xh[j-1];
          yh[j] <= yh[j-1];
        end
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R8
  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_data))); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst) (delay_set && !busy) |=> busy); // R2
  AST_SET_IGNORED: assert property (@(posedge clk) disable iff (rst) (busy && delay_set) |=> $stable(dcode)); // R3
  AST_ZERO_CLAMP: assert property (@(posedge clk) disable iff (rst) (delay_set && !busy && delay_in == '0) |=> (delay_err && dcode == DELAY_W'(1))); // R4
  AST_COEF_HOLD: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(coef_cur[1])); // R6

endmodule

// File: tb/sim_thiran_allpass_delay.sv
module sim_thiran_allpass_delay;
  localparam int N   = 2;
  localparam int CWD = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic delay_set = 1'b0;
  logic [15:0] delay_in = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;
  logic busy, delay_err;

  thiran_allpass_delay #(.ORDER(N), .COEF_W(CWD)) u0 (
    .clk(clk), .rst(rst), .delay_set(delay_set), .delay_in(delay_in),
    .in_valid(in_valid), .in_data(in_data), .out_valid(out_valid),
    .out_data(out_data), .busy(busy), .delay_err(delay_err));

  always #5 clk = ~clk;

  int total = 0, bad = 0, cyc = 0, sat_seen = 0;
  bit finished = 0;
  longint ca [0:N], pa [0:N], mx [1:N], my [1:N];
  bit have_pend = 0;
  longint last_out = 0;
  logic [15:0] lf = 16'hACE1;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 190000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint fact(input int n);
    longint f = 1;
    for (int i = 2; i <= n; i++) f = f * i;
    return f;
  endfunction

  function automatic longint mcoef(input int k, input int d);
    logic signed [127:0] p, q, mg, m;
    longint r;
    bit pn;
    p = 1; q = 1;
    for (int i = 1; i <= k; i++) begin
      p = p * (d - (N + 1 - i) * 4096);
      q = q * (d + i * 4096);
    end
    pn = (p < 0);
    mg = pn ? -p : p;
    m = (mg * (fact(N) / (fact(k) * fact(N - k))) * 65536 + q / 2) / q;
    r = longint'(m);
    if ((k % 2 == 1) != pn) r = -r;
    return r;
  endfunction

  function automatic longint model_step(input longint x);
    longint acc, y;
    if (have_pend) begin
      for (int i = 1; i <= N; i++) ca[i] = pa[i];
      have_pend = 0;
    end
    acc = ca[N] * x;
    for (int j = 1; j <= N; j++) acc = acc + ca[N-j] * mx[j] - ca[j] * my[j];
    y = (acc + 32768) >>> 16;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    for (int j = N; j >= 2; j--) begin
      mx[j] = mx[j-1];
      my[j] = my[j-1];
    end
    mx[1] = x;
    my[1] = y;
    return y;
  endfunction

  task automatic sample(input longint x, input string req);
    longint e;
    in_valid = 1'b1;
    in_data = 16'(x);
    e = model_step(x);
    @(negedge clk);
    chk(out_valid == 1'b1, "R8 valid", longint'(out_valid), 1);
    chk(longint'(out_data) == e, req, longint'(out_data), e);
    if (e == 32767 || e == -32768) begin
      sat_seen++;
      chk(longint'(out_data) == e, "R9", longint'(out_data), e);
    end
    last_out = e;
    in_valid = 1'b0;
  endtask

  task automatic idle_chk();
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 idle valid", longint'(out_valid), 0);
    chk(longint'(out_data) == last_out, "R8 hold", longint'(out_data), last_out);
  endtask

  function automatic longint lfsr_next();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return longint'($signed(lf));
  endfunction

  task automatic load(input int d, input bit inject, input int d2, input bit traffic);
    int cnt, deff;
    delay_set = 1'b1;
    delay_in = 16'(d);
    @(negedge clk);
    delay_set = 1'b0;
    chk(busy == 1'b1, "R2 busy rise", longint'(busy), 1);
    chk(delay_err == (d == 0), "R4 err", longint'(delay_err), longint'(d == 0));
    cnt = 0;
    while (busy && cnt < 1000) begin
      delay_set = (inject && cnt == 3);
      delay_in = inject && cnt == 3 ? 16'(d2) : 16'(d);
      if (traffic) sample(lfsr_next() >>> 2, "R6 old set during busy");
      else @(negedge clk);
      delay_set = 1'b0;
      cnt++;
    end
    chk(cnt == N * (CWD + 1), inject ? "R3 busy length" : "R2 busy length", cnt, N * (CWD + 1));
    deff = (d == 0) ? 1 : d;
    for (int k = 1; k <= N; k++) pa[k] = mcoef(k, deff);
    have_pend = 1;
  endtask

  initial begin
    longint h1, h2, x, e;
    int d;
    ca[0] = 65536; pa[0] = 65536;
    for (int i = 1; i <= N; i++) begin ca[i] = 0; pa[i] = 0; mx[i] = 0; my[i] = 0; end
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_data == 0, "R1 outputs", longint'(out_data), 0);
    chk(busy == 0 && delay_err == 0, "R1 flags", longint'(busy) + longint'(delay_err), 0);
    rst = 1'b0;
    sample(100, "R1 pure delay");
    sample(-200, "R1 pure delay");
    sample(300, "R1 pure delay");
    sample(400, "R1 pure delay");
    idle_chk();

    load(N * 4096, 0, 0, 0);
    h1 = 300; h2 = 400;
    for (int i = 0; i < 8; i++) begin
      x = lfsr_next();
      sample(x, "R10 model");
      chk(last_out == h1, "R10 exact delay", last_out, h1);
      h1 = h2; h2 = x;
    end

    load(0, 0, 0, 0);
    for (int i = 0; i < 6; i++) sample(i == 0 ? 9000 : 0, "R4 clamped delay");
    load(4096, 0, 0, 0);
    chk(delay_err == 0, "R4 err clear", longint'(delay_err), 0);
    for (int i = 0; i < 6; i++) sample(lfsr_next() >>> 1, "R7 D=1");
    idle_chk();

    load(6000, 1, 20000, 0);
    for (int i = 0; i < 8; i++) sample(i == 0 ? 12000 : 0, "R3 first delay kept");
    load(11000, 0, 0, 1);
    for (int i = 0; i < 6; i++) sample(lfsr_next() >>> 2, "R6 new set at boundary");
    idle_chk();

    for (int s = 0; s < 72; s++) begin
      if (s < 6) d = (s == 0) ? 1 : (s == 1) ? 4095 : (s == 2) ? 8193 : (s == 3) ? 65535 : (s == 4) ? 2048 : 12288;
      else d = ((s * 1103) + 7) % 65536;
      load(d, 0, 0, 0);
      for (int i = 0; i < 10; i++) begin
        case (s % 3)
          0: x = (i == 0) ? 16000 : 0;
          1: x = (i % 2 == 0) ? 32767 : -32768;
          default: x = lfsr_next();
        endcase
        sample(x, "R5 R7 sweep");
      end
      idle_chk();
    end
    chk(sat_seen > 0, "R9 exercised", sat_seen, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule